// File: doc/BRIEF.md
# Interrupt Status and Mask Register Pair

This block holds two registers on a small configuration bus. The first is an interrupt status register. Each bit latches a hardware event and holds it until software clears it. Software clears a bit by writing a one to that bit position. Writing a zero leaves the bit alone, and no software write can set a status bit. The second register is a mask register that software can read and write freely. A mask bit of one keeps the matching status bit from raising the interrupt line. The status bit still latches its event while masked.

A handler reads the status register, services the pending causes, and writes the same value back to acknowledge them. It can mask or unmask causes at any time. An event that arrives in the same cycle as its acknowledge is kept, so no event is lost. Both the read data and the interrupt line come from registers.

Top module: `irq_pair`

## Requirements
- R1: On reset the status register is zero, the mask register holds the parameter MASK_INIT (default 8'hF0), and irq_out is 0.
- R2: A status bit becomes 1 at the first clock edge where its hw_set bit is high. It stays 1 until software clears it.
- R3: Writing to the status address clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: No write to the status address ever changes a status bit from 0 to 1.
- R5: The mask register takes the write data on a write to the mask address, and it reads back unchanged.
- R6: A status bit latches its hw_set event even when its mask bit is 1.
- R7: At every clock edge, irq_out is loaded with the OR over all bits of (status AND NOT mask), using the values those registers held before the edge. irq_out therefore lags a register change by one cycle.
- R8: If hw_set and a software clear reach the same status bit at the same edge, the bit ends up 1.
- R9: The status register sits at address BASE_ADDR (default 4) and the mask register at BASE_ADDR+1. A read of any other address returns 0. A write to any other address changes neither register.
- R10: bus_rdata is registered. It shows the addressed register one cycle after bus_rd_en is high, and it is 0 in any cycle that follows a cycle with bus_rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write enable |
| bus_rd_en | input | 1 | Read enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| hw_set | input | DATA_W | Per-bit event inputs from hardware |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a hardware event and a software acknowledge landing on the same bit at the same edge. The bench builds that edge on purpose. One task drives a write of ones to the status address and raises hw_set on the same bit, in the same half-cycle. The bench then reads the bit back as still set. A second case is a bit that latches while masked and then raises irq_out only once it is unmasked. The bench reaches it by changing the mask between the event and the check.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Offsets of the two registers from the block's base address
  localparam int STATUS_OFS = 0;
  localparam int MASK_OFS   = 1;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_status,
  output logic              sel_mask
);
  import irq_pkg::*;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(BASE_ADDR + STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(BASE_ADDR + MASK_OFS);

  always_comb begin
    sel_status = (addr == STATUS_ADDR);
    sel_mask   = (addr == MASK_ADDR);
  end

  // R9: a single address never selects both registers
  a_r9_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_status, sel_mask}));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_bits,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] status
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              status[i] <= 1'b0;
      else if (set_bits[i]) status[i] <= 1'b1;   // set outranks clear
      else if (clr_bits[i]) status[i] <= 1'b0;
    end
  end

  // R8: every bit being set ends up 1, even when it is also being cleared
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((status & $past(set_bits)) == $past(set_bits)));
  // R3: a bit cleared without a concurrent set ends up 0
  a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
    (|(clr_bits & ~set_bits)) |=> ((status & $past(clr_bits & ~set_bits)) == '0));
  // R4: a bit goes from 0 to 1 only through a set request
  a_r4_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_bits)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] MASK_INIT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)        mask <= MASK_INIT;
    else if (wr_en) mask <= wdata;
  end

  // R5: the mask changes only on a write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask));
endmodule

// File: rtl/irq_pair.sv
module irq_pair #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                BASE_ADDR = 4,
  parameter logic [DATA_W-1:0] MASK_INIT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic              irq_out
);
  logic              sel_status, sel_mask;
  logic [DATA_W-1:0] status, mask, clr_bits;

  irq_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .sel_status(sel_status), .sel_mask(sel_mask)
  );

  always_comb clr_bits = (bus_wr_en && sel_status) ? bus_wdata : '0;

  irq_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .set_bits(hw_set), .clr_bits(clr_bits), .status(status)
  );

  irq_mask_reg #(.DATA_W(DATA_W), .MASK_INIT(MASK_INIT)) u_mask (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en && sel_mask), .wdata(bus_wdata), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= |(status & ~mask);
      if (bus_rd_en && sel_status)    bus_rdata <= status;
      else if (bus_rd_en && sel_mask) bus_rdata <= mask;
      else                            bus_rdata <= '0;
    end
  end

  // R7: the interrupt follows the unmasked status one cycle later
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == |($past(status) & ~$past(mask))));
  // R10: the read data is zero after a cycle with no read
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> (bus_rdata == '0));
endmodule

// File: tb/irq_pair_tb.sv
module irq_pair_tb;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_ST = 4'd4;
  localparam logic [ADDR_W-1:0] A_MK = 4'd5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0, hw_set = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_out;
  int errors = 0, checks = 0;
  logic [DATA_W-1:0] rv;

  always #4 clk = ~clk;

  irq_pair #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(4), .MASK_INIT(8'hF0)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_set(hw_set), .irq_out(irq_out)
  );

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [DATA_W-1:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; hw_set = s;
    @(negedge clk);
    bus_wr_en = 1'b0; hw_set = '0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_set(logic [DATA_W-1:0] s);
    @(negedge clk); hw_set = s;
    @(negedge clk); hw_set = '0;
  endtask

  task automatic t_reset();
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    bus_read(A_ST, rv); check("R1 status", rv, 8'h00);
    bus_read(A_MK, rv); check("R1 mask", rv, 8'hF0);
  endtask

  task automatic t_set_and_irq();
    pulse_set(8'h01);                 // status set at this edge
    check("R7 irq lag", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    check("R7 irq", {7'd0, irq_out}, 8'h01);
    repeat (3) @(negedge clk);
    bus_read(A_ST, rv); check("R2 status held", rv, 8'h01);
  endtask

  task automatic t_w1c();
    bus_write(A_ST, 8'h00, 8'h00);
    bus_write(A_ST, 8'hFE, 8'h00);
    bus_read(A_ST, rv); check("R3 zeros keep", rv, 8'h01);
    bus_write(A_ST, 8'h01, 8'h00);
    bus_read(A_ST, rv); check("R3 clear", rv, 8'h00);
    check("R7 irq drop", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_no_sw_set();
    bus_write(A_ST, 8'hFF, 8'h00);
    bus_read(A_ST, rv); check("R4 no set", rv, 8'h00);
  endtask

  task automatic t_mask();
    bus_write(A_MK, 8'h5A, 8'h00);
    bus_read(A_MK, rv); check("R5 mask rw", rv, 8'h5A);
    pulse_set(8'h02);
    @(negedge clk);
    bus_read(A_ST, rv); check("R6 masked latch", rv, 8'h02);
    check("R7 masked irq", {7'd0, irq_out}, 8'h00);
    bus_write(A_MK, 8'h00, 8'h00);    // mask reg loads at this edge
    check("R7 unmask lag", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    check("R7 unmask irq", {7'd0, irq_out}, 8'h01);
  endtask

  task automatic t_collision();
    bus_write(A_ST, 8'h02, 8'h02);
    bus_read(A_ST, rv); check("R8 set wins", rv, 8'h02);
    bus_write(A_ST, 8'h02, 8'h04);
    bus_read(A_ST, rv); check("R8 other bit", rv, 8'h04);
    bus_write(A_ST, 8'hFF, 8'h00);
    bus_read(A_ST, rv); check("R3 clear all", rv, 8'h00);
  endtask

  task automatic t_address();
    bus_write(A_MK, 8'h3C, 8'h00);
    bus_write(4'd6, 8'hFF, 8'h00);
    bus_write(4'd3, 8'hFF, 8'h00);
    bus_read(4'd6, rv); check("R9 unmapped 6", rv, 8'h00);
    bus_read(4'd3, rv); check("R9 unmapped 3", rv, 8'h00);
    bus_read(A_MK, rv); check("R9 mask untouched", rv, 8'h3C);
    pulse_set(8'h80);
    bus_write(4'd0, 8'hFF, 8'h00);
    bus_read(A_ST, rv); check("R9 status untouched", rv, 8'h80);
  endtask

  task automatic t_rdata_reg();
    bus_read(A_MK, rv); check("R10 read", rv, 8'h3C);
    @(negedge clk);
    check("R10 idle zero", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_and_irq();
    t_w1c();
    t_no_sw_set();
    t_mask();
    t_collision();
    t_address();
    t_rdata_reg();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule